// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs an 8-bit accumulator that holds the plain binary sum of two packed-BCD bytes. It uses the carry and digit-carry flags left by that addition and produces a valid two-digit BCD byte. Each 4-bit digit is corrected on its own. A digit that exceeds nine, or whose flag is set, gets six added modulo sixteen. Nothing carries from the low digit into the high digit.

One instruction runs over four quarter-cycle phases: decode, read the target location, execute, write. The corrected byte always goes to the register-file location named in the instruction. A destination bit decides whether the accumulator also receives it. The carry flag is rewritten to show whether the high digit was corrected. The unit has no output for the digit-carry flag, so that flag cannot be changed.

The host pulses a start strobe together with a 16-bit instruction word and the current accumulator and flags. It then watches the phase output and the write strobes.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The low result digit (bits 3:0) equals the low accumulator digit plus 6, modulo 16, when that digit is greater than 9 or the digit-carry input is 1. Otherwise it equals the low accumulator digit unchanged.
- R2: The high result digit (bits 7:4) equals the high accumulator digit plus 6, modulo 16, when that digit is greater than 9 or the carry input is 1. Otherwise it equals the high accumulator digit unchanged.
- R3: Correcting the low digit never changes the high digit. For example, 0x9A with both flags 0 gives 0x90, and 0xCE gives 0x24.
- R4: In the write phase, carry_we_o is 1 and carry_o is 1 exactly when the high digit was corrected. carry_we_o is 0 in every other cycle.
- R5: In the write phase, acc_we_o is 1 with acc_wdata_o equal to the result when instruction bit 8 is 0. When that bit is 1, acc_we_o stays 0.
- R6: rf_addr_o carries instruction bits 7:0 from the read phase to the write phase. rf_wr_en_o is 1 only in the write phase, and rf_wdata_o then holds the result.
- R7: A start accepted in idle (phase_o = 0) steps phase_o through 1 (decode), 2 (read), 3 (execute), 4 (write) and back to 0 on successive clocks. rf_rd_en_o is 1 only in phase 2.
- R8: A start whose instruction bits 15:9 differ from 0010111 is ignored. phase_o stays 0 and no strobe rises.
- R9: A start offered while phase_o is not 0 is ignored. The running operation finishes with the data captured at its own start, and the unit then returns to 0.
- R10: During and after reset, phase_o is 0, busy_o is 0 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| instr_i | input | 16 | Instruction word: opcode 15:9, destination bit 8, address 7:0 |
| acc_i | input | 8 | Accumulator value before the adjust |
| carry_i | input | 1 | Carry flag from the preceding addition |
| dcarry_i | input | 1 | Digit-carry flag from the preceding addition |
| phase_o | output | 3 | 0 idle, 1 decode, 2 read, 3 execute, 4 write |
| busy_o | output | 1 | An operation is in progress |
| rf_addr_o | output | 8 | Register-file address |
| rf_rd_en_o | output | 1 | Register-file read strobe |
| rf_wr_en_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 8 | Register-file write data |
| acc_we_o | output | 1 | Accumulator write enable |
| acc_wdata_o | output | 8 | Accumulator write data |
| carry_we_o | output | 1 | Carry flag write enable |
| carry_o | output | 1 | New carry flag value |

## Verification
With the destination bit 0, the memory write, the accumulator write and the carry update all land in the same write-phase cycle. The bench samples all three ports in that one cycle and compares them with the expected byte and flag. The vector table mixes both destination settings so that acc_we_o must follow bit 8 while the memory write always occurs. A second start is also offered in the middle of a running operation. The bench judges it by checking that the result still comes from the first operation's data and that the phase returns to idle.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int OPC_W = 7;
    localparam logic [OPC_W-1:0] OPC_ADJUST = 7'b0010111;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEC   = 3'd1,
        PH_READ  = 3'd2,
        PH_EXEC  = 3'd3,
        PH_WRITE = 3'd4
    } phase_e;

endpackage

// File: rtl/bcd_adj_decode.sv
module bcd_adj_decode
    import bcd_adj_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int INSTR_W = OPC_W + 1 + ADDR_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic               mem_only,
    output logic [ADDR_W-1:0]  addr
);
    // opcode in the top bits, destination select just below, address at the bottom
    always_comb begin
        hit      = (instr[INSTR_W-1 -: OPC_W] == OPC_ADJUST);
        mem_only = instr[ADDR_W];
        addr     = instr[ADDR_W-1:0];
    end
endmodule

// File: rtl/bcd_adj_digit.sv
module bcd_adj_digit #(
    parameter int NIB_W = 4,
    parameter int LIMIT = 9,
    parameter int BONUS = 6
) (
    input  logic [NIB_W-1:0] nib,
    input  logic             force_fix,
    output logic [NIB_W-1:0] nib_fixed,
    output logic             fixed
);
    localparam logic [NIB_W-1:0] LIM_V = NIB_W'(LIMIT);
    localparam logic [NIB_W-1:0] ADD_V = NIB_W'(BONUS);

    always_comb begin
        fixed     = force_fix || (nib > LIM_V);
        nib_fixed = fixed ? (nib + ADD_V) : nib;
    end
endmodule

// File: rtl/bcd_adj_seq.sv
module bcd_adj_seq
    import bcd_adj_pkg::*;
(
    input  phase_e cur,
    input  logic   start,
    input  logic   hit,
    output phase_e nxt,
    output logic   accept
);
    always_comb begin
        accept = 1'b0;
        nxt    = cur;
        unique case (cur)
            PH_IDLE: begin
                if (start && hit) begin
                    accept = 1'b1;
                    nxt    = PH_DEC;
                end
            end
            PH_DEC:   nxt = PH_READ;
            PH_READ:  nxt = PH_EXEC;
            PH_EXEC:  nxt = PH_WRITE;
            PH_WRITE: nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int DIGITS  = DATA_W / NIB_W,
    localparam int INSTR_W = OPC_W + 1 + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic               carry_i,
    input  logic               dcarry_i,
    output logic [2:0]         phase_o,
    output logic               busy_o,
    output logic [ADDR_W-1:0]  rf_addr_o,
    output logic               rf_rd_en_o,
    output logic               rf_wr_en_o,
    output logic [DATA_W-1:0]  rf_wdata_o,
    output logic               acc_we_o,
    output logic [DATA_W-1:0]  acc_wdata_o,
    output logic               carry_we_o,
    output logic               carry_o
);

    typedef struct packed {
        phase_e              phase;
        logic                mem_only;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   acc;
        logic                cy;
        logic                dcy;
        logic [DATA_W-1:0]   res;
        logic                cout;
    } state_t;

    state_t s_d, s_q;

    logic              dec_hit, dec_mem_only, accept_w;
    logic [ADDR_W-1:0] dec_addr;
    phase_e            phase_nxt_w;
    logic [DATA_W-1:0] fix_w;
    logic [DIGITS-1:0] adj_w, force_w;

    bcd_adj_decode #(.ADDR_W(ADDR_W)) i_decode (
        .instr    (instr_i),
        .hit      (dec_hit),
        .mem_only (dec_mem_only),
        .addr     (dec_addr)
    );

    bcd_adj_seq i_seq (
        .cur    (s_q.phase),
        .start  (start_i),
        .hit    (dec_hit),
        .nxt    (phase_nxt_w),
        .accept (accept_w)
    );

    // one corrector per digit; the lowest digit takes digit-carry, the highest takes carry
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        if (g == 0) begin : g_lo
            assign force_w[g] = s_q.dcy;
        end else if (g == DIGITS-1) begin : g_hi
            assign force_w[g] = s_q.cy;
        end else begin : g_mid
            assign force_w[g] = 1'b0;
        end

        bcd_adj_digit #(.NIB_W(NIB_W)) i_digit (
            .nib       (s_q.acc[g*NIB_W +: NIB_W]),
            .force_fix (force_w[g]),
            .nib_fixed (fix_w[g*NIB_W +: NIB_W]),
            .fixed     (adj_w[g])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_nxt_w;
        if (accept_w) begin
            s_d.mem_only = dec_mem_only;
            s_d.addr     = dec_addr;
            s_d.acc      = acc_i;
            s_d.cy       = carry_i;
            s_d.dcy      = dcarry_i;
        end
        if (s_q.phase == PH_EXEC) begin
            s_d.res  = fix_w;
            s_d.cout = adj_w[DIGITS-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        phase_o     = s_q.phase;
        busy_o      = (s_q.phase != PH_IDLE);
        rf_addr_o   = s_q.addr;
        rf_rd_en_o  = (s_q.phase == PH_READ);
        rf_wr_en_o  = (s_q.phase == PH_WRITE);
        rf_wdata_o  = s_q.res;
        acc_we_o    = (s_q.phase == PH_WRITE) && !s_q.mem_only;
        acc_wdata_o = s_q.res;
        carry_we_o  = (s_q.phase == PH_WRITE);
        carry_o     = s_q.cout;
    end

endmodule

// File: rtl/bcd_adj_checker.sv
module bcd_adj_checker
    import bcd_adj_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int INSTR_W = OPC_W + 1 + ADDR_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  acc_i,
    input logic               carry_i,
    input logic               dcarry_i,
    input logic [2:0]         phase_o,
    input logic               busy_o,
    input logic [ADDR_W-1:0]  rf_addr_o,
    input logic               rf_rd_en_o,
    input logic               rf_wr_en_o,
    input logic [DATA_W-1:0]  rf_wdata_o,
    input logic               acc_we_o,
    input logic               carry_we_o,
    input logic               carry_o
);
    a_r6_write_in_q4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> phase_o == 3'd4);
    a_r5_acc_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |-> rf_wr_en_o);
    a_r4_carry_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we_o |-> rf_wr_en_o);
    a_r4_write_with_carry: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> carry_we_o);
    a_r7_dec_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd1 |=> phase_o == 3'd2);
    a_r7_read_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd2 |=> phase_o == 3'd3);
    a_r7_exec_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd3 |=> phase_o == 3'd4);
    a_r7_write_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd4 |=> phase_o == 3'd0);
    a_r7_read_in_q2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |-> phase_o == 3'd2);
    a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0 && start_i && instr_i[INSTR_W-1 -: OPC_W] != OPC_ADJUST)
        |=> phase_o == 3'd0);
    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd3 || phase_o == 3'd4) |-> $stable(rf_addr_o));
    a_r1_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en_o && !$past(dcarry_i, 4) && $past(acc_i[3:0], 4) <= 4'd9)
        |-> rf_wdata_o[3:0] == $past(acc_i[3:0], 4));
    a_r2_carry_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en_o && $past(carry_i, 4)) |-> carry_o);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(rf_rd_en_o || rf_wr_en_o || acc_we_o || carry_we_o));
endmodule

bind bcd_adjust_unit bcd_adj_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .instr_i    (instr_i),
    .acc_i      (acc_i),
    .carry_i    (carry_i),
    .dcarry_i   (dcarry_i),
    .phase_o    (phase_o),
    .busy_o     (busy_o),
    .rf_addr_o  (rf_addr_o),
    .rf_rd_en_o (rf_rd_en_o),
    .rf_wr_en_o (rf_wr_en_o),
    .rf_wdata_o (rf_wdata_o),
    .acc_we_o   (acc_we_o),
    .carry_we_o (carry_we_o),
    .carry_o    (carry_o)
);

// File: tb/test_bcd_adjust_unit.sv
`timescale 1ns/1ps
module test_bcd_adjust_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [7:0]  acc_i = '0;
    logic        carry_i = 1'b0;
    logic        dcarry_i = 1'b0;
    logic [2:0]  phase_o;
    logic        busy_o;
    logic [7:0]  rf_addr_o;
    logic        rf_rd_en_o, rf_wr_en_o;
    logic [7:0]  rf_wdata_o;
    logic        acc_we_o;
    logic [7:0]  acc_wdata_o;
    logic        carry_we_o, carry_o;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    bcd_adjust_unit i_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .acc_i(acc_i), .carry_i(carry_i), .dcarry_i(dcarry_i),
        .phase_o(phase_o), .busy_o(busy_o), .rf_addr_o(rf_addr_o),
        .rf_rd_en_o(rf_rd_en_o), .rf_wr_en_o(rf_wr_en_o), .rf_wdata_o(rf_wdata_o),
        .acc_we_o(acc_we_o), .acc_wdata_o(acc_wdata_o),
        .carry_we_o(carry_we_o), .carry_o(carry_o)
    );

    // {acc, carry, dcarry, mem_only, addr, expected byte, expected carry}
    localparam logic [27:0] VEC [0:11] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 8'h10, 8'h05, 1'b1},
        {8'hCE, 1'b0, 1'b0, 1'b1, 8'h11, 8'h24, 1'b1},
        {8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
        {8'h99, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h99, 1'b0},
        {8'h9A, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h90, 1'b0},
        {8'h3F, 1'b0, 1'b0, 1'b1, 8'h42, 8'h35, 1'b0},
        {8'h12, 1'b0, 1'b1, 1'b0, 8'h07, 8'h18, 1'b0},
        {8'h12, 1'b1, 1'b0, 1'b1, 8'h80, 8'h72, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h55, 1'b1},
        {8'h45, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hAB, 1'b1},
        {8'h09, 1'b0, 1'b1, 1'b0, 8'h01, 8'h0F, 1'b0},
        {8'hB0, 1'b0, 1'b0, 1'b1, 8'hFE, 8'h10, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // drives one instruction and checks each phase; inputs are scrambled after the start edge
    task automatic run_op(input logic [7:0] a, input logic c, input logic dc, input logic mo,
                          input logic [7:0] ad, input logic [7:0] er, input logic ec,
                          input bit poke_busy);
        @(negedge clk);
        start_i = 1'b1; instr_i = {7'b0010111, mo, ad}; acc_i = a; carry_i = c; dcarry_i = dc;
        @(negedge clk);
        start_i = 1'b0; acc_i = ~a; carry_i = ~c; dcarry_i = ~dc; instr_i = 16'hFFFF;
        chk(phase_o == 3'd1 && busy_o, "R7 decode phase", 32'(phase_o), 32'd1);
        @(negedge clk);
        chk(phase_o == 3'd2 && rf_rd_en_o && !rf_wr_en_o, "R7 read phase", 32'({phase_o, rf_rd_en_o}), 32'({3'd2, 1'b1}));
        chk(rf_addr_o == ad, "R6 address", 32'(rf_addr_o), 32'(ad));
        if (poke_busy) begin
            // R9: a fresh start in the middle must be ignored
            start_i = 1'b1; instr_i = {7'b0010111, 1'b0, 8'h66}; acc_i = 8'h77; carry_i = 1'b1; dcarry_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(phase_o == 3'd3 && !rf_wr_en_o && !carry_we_o && !acc_we_o, "R6 no early write",
            32'({phase_o, rf_wr_en_o}), 32'({3'd3, 1'b0}));
        @(negedge clk);
        chk(phase_o == 3'd4 && rf_wr_en_o && rf_addr_o == ad, "R6 write strobe/address",
            32'({rf_wr_en_o, rf_addr_o}), 32'({1'b1, ad}));
        chk(rf_wdata_o[3:0] == er[3:0], "R1 low digit", 32'(rf_wdata_o[3:0]), 32'(er[3:0]));
        chk(rf_wdata_o[7:4] == er[7:4], "R2 R3 high digit", 32'(rf_wdata_o[7:4]), 32'(er[7:4]));
        chk(carry_we_o && carry_o == ec, "R4 carry", 32'({carry_we_o, carry_o}), 32'({1'b1, ec}));
        chk(acc_we_o == !mo, "R5 acc enable", 32'(acc_we_o), 32'(!mo));
        if (!mo) chk(acc_wdata_o == er, "R5 acc data", 32'(acc_wdata_o), 32'(er));
        @(negedge clk);
        chk(phase_o == 3'd0 && !busy_o && !rf_wr_en_o, "R7 R9 back to idle", 32'(phase_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(phase_o == 3'd0 && !busy_o && !rf_rd_en_o && !rf_wr_en_o && !acc_we_o && !carry_we_o,
            "R10 reset state", 32'(phase_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase_o == 3'd0, "R10 idle after release", 32'(phase_o), 32'd0);

        for (int i = 0; i < 12; i++) begin
            run_op(VEC[i][27:20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9],
                   VEC[i][8:1], VEC[i][0], 1'b0);
        end

        // R3 explicit: low fix wraps without touching the high digit
        run_op(8'h9F, 1'b0, 1'b0, 1'b0, 8'h20, 8'h95, 1'b0, 1'b0);

        // R9: start while busy, first operation's data must win
        run_op(8'h34, 1'b0, 1'b0, 1'b1, 8'h33, 8'h34, 1'b0, 1'b1);

        // R8: wrong opcode is ignored
        @(negedge clk);
        start_i = 1'b1; instr_i = {7'b0010110, 1'b0, 8'h12}; acc_i = 8'hAA;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(phase_o == 3'd0 && !rf_rd_en_o && !rf_wr_en_o && !acc_we_o && !carry_we_o,
                "R8 bad opcode ignored", 32'(phase_o), 32'd0);
            @(negedge clk);
        end

        // R10: reset in the middle of an operation
        start_i = 1'b1; instr_i = {7'b0010111, 1'b0, 8'h44}; acc_i = 8'hAA;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(phase_o == 3'd0 && !busy_o && !rf_wr_en_o && !acc_we_o && !carry_we_o,
            "R10 reset mid-operation", 32'(phase_o), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(phase_o == 3'd0 && !rf_wr_en_o, "R10 stays idle", 32'(phase_o), 32'd0);

        finish_run();
    end

endmodule